// File: doc/BRIEF.md
# Pipelined RC6-Style Block Encryption Datapath

This block encrypts 128-bit blocks with an RC6-style round function. A block is split into four 32-bit words A, B, C and D. It passes through a whitening step on entry, a fixed number of identical rounds and a whitening step on exit. Round subkeys live in a small word-addressed store. A key-expansion engine outside the block fills that store through a simple write port before any traffic flows.

The rounds are fully unrolled. Each round is cut into 1 to 4 register stages, chosen at compile time. Latency is therefore ROUNDS x STAGES cycles while throughput stays at one block per cycle. Fewer stages save flops at the cost of a longer path through the 32-bit multiplier. The input has a valid/ready pair and the output is a plain valid strobe with no backpressure.

Top module: `rc6_pipe`

## Requirements
- R1: While reset is asserted and after its release, out_valid_o is low. in_ready_o is high whenever key_we_i is low.
- R2: A block presented with in_valid_i and in_ready_o high in cycle n appears with out_valid_o high in cycle n + ROUNDS*STAGES, for STAGES of 1, 2, 3 or 4.
- R3: A new block is accepted every cycle in which in_valid_i is high and in_ready_o is high. Results leave in acceptance order, one per cycle, with no gaps for back-to-back input.
- R4: Each round i (1..ROUNDS) works as follows, with rotl a 32-bit left rotation:
  - It computes t = rotl(B*(2B+1) mod 2^32, 5) and u = rotl(D*(2D+1) mod 2^32, 5).
  - It then forms A' = rotl(A^t, u[4:0]) + S[2i] and C' = rotl(C^u, t[4:0]) + S[2i+1].
  - The new words are (A,B,C,D) = (B, C', D, A'), with all additions mod 2^32.
- R5: Before round 1, S[0] is added to B and S[1] is added to D. After the last round, S[2*ROUNDS+2] is added to A and S[2*ROUNDS+3] is added to C.
- R6: Words are little-endian on both data ports. A is bits [31:0], B is [63:32], C is [95:64] and D is [127:96], so byte 0 of the block is the low byte of A.
- R7: While key_we_i is high, in_ready_o is low and a block offered on in_valid_i is dropped: it yields no output.
- R8: A write with key_we_i high and key_addr_i = a, with a in 0..2*ROUNDS+3, stores key_data_i as subkey S[a]. Blocks accepted afterwards use the new value.
- R9: A write whose address is above 2*ROUNDS+3 changes no subkey.
- R10: out_valid_o is high only for blocks that were accepted. Every accepted block produces exactly one output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Plaintext block offered |
| in_ready_o | output | 1 | Block can be taken this cycle |
| in_data_i | input | 128 | Plaintext, little-endian words A..D |
| key_we_i | input | 1 | Subkey write strobe |
| key_addr_i | input | $clog2(2*ROUNDS+4) | Subkey index |
| key_data_i | input | 32 | Subkey value |
| out_valid_o | output | 1 | Ciphertext valid |
| out_data_o | output | 128 | Ciphertext, little-endian words A..D |

## Verification
The bench builds three copies side by side with ROUNDS = 10 and STAGES set to 1, 2 and 4. The same stimulus therefore covers the shortest path (one register per round, latency 10), the default split (latency 20) and the deepest split (latency 40). Each placement of the cut points in the round is checked against one reference model. Running the deepest copy together with the shallowest one also shows that a block's result and its timing do not depend on how many blocks are in flight. With ROUNDS = 10 there are 24 subkeys on a 5-bit address, which leaves addresses 24 to 31 free to show that out-of-range writes are ignored.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BLOCK_W = 4 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  // a..d: block words; x/y: intermediate products / rotation sources
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t x;
    word_t y;
  } rstate_t;

  function automatic word_t rotl(input word_t v, input logic [4:0] n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // register placement after each of the four round steps
  function automatic bit cut_after(input int unsigned stages, input int unsigned step);
    case (stages)
      1:       return step == 3;
      2:       return (step == 0) || (step == 3);
      3:       return step != 1;
      default: return 1'b1;
    endcase
  endfunction

  function automatic rstate_t round_step(input int unsigned step, input rstate_t s,
                                         input word_t k0, input word_t k1);
    rstate_t r;
    word_t   t, u;
    r = s;
    case (step)
      0: begin
        r.x = s.b * {s.b[WORD_W-2:0], 1'b1};
        r.y = s.d * {s.d[WORD_W-2:0], 1'b1};
      end
      1: begin
        t   = rotl(s.x, 5'd5);
        u   = rotl(s.y, 5'd5);
        r.a = s.a ^ t;
        r.c = s.c ^ u;
        r.x = t;
        r.y = u;
      end
      2: begin
        r.a = rotl(s.a, s.y[4:0]);
        r.c = rotl(s.c, s.x[4:0]);
      end
      default: begin
        r.a = s.b;
        r.b = s.c + k1;
        r.c = s.d;
        r.d = s.a + k0;
      end
    endcase
    return r;
  endfunction

  function automatic rstate_t load_block(input logic [BLOCK_W-1:0] blk,
                                         input word_t k0, input word_t k1);
    rstate_t r;
    r.a = blk[0*WORD_W +: WORD_W];
    r.b = blk[1*WORD_W +: WORD_W] + k0;
    r.c = blk[2*WORD_W +: WORD_W];
    r.d = blk[3*WORD_W +: WORD_W] + k1;
    r.x = '0;
    r.y = '0;
    return r;
  endfunction

  function automatic logic [BLOCK_W-1:0] unload_block(input rstate_t s,
                                                      input word_t ka, input word_t kc);
    return {s.d, s.c + kc, s.b, s.a + ka};
  endfunction
endpackage

// File: rtl/rc6_key_store.sv
module rc6_key_store
  import rc6_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 24,
  parameter int unsigned ADDR_W    = $clog2(KEY_WORDS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  word_t                             data_i,
  output logic [KEY_WORDS-1:0][WORD_W-1:0]  keys_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(KEY_WORDS - 1);

  logic [KEY_WORDS-1:0][WORD_W-1:0] keys_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keys_q <= '0;
    end else if (we_i && (addr_i <= LAST)) begin
      keys_q[addr_i] <= data_i;
    end
  end

  assign keys_o = keys_q;

  p_key_oob_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i > LAST)) |=> $stable(keys_q));

  p_key_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i <= LAST)) |=> (keys_q[$past(addr_i)] == $past(data_i)));
endmodule

// File: rtl/rc6_round.sv
module rc6_round
  import rc6_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  rstate_t state_i,
  input  word_t   k0_i,
  input  word_t   k1_i,
  output logic    valid_o,
  output rstate_t state_o
);
  localparam int unsigned STEPS = 4;

  logic [STEPS:0] vld;
  rstate_t        st [STEPS+1];

  assign vld[0] = valid_i;
  assign st[0]  = state_i;

  for (genvar j = 0; j < STEPS; j++) begin : g_step
    rstate_t nxt;
    logic    v_out;
    rstate_t s_out;

    assign nxt = round_step(j, st[j], k0_i, k1_i);

    if (cut_after(STAGES, j)) begin : g_cut
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_out <= 1'b0;
          s_out <= '0;
        end else begin
          v_out <= vld[j];
          s_out <= nxt;
        end
      end

      p_stage_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld[j] |=> v_out);
      p_stage_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld[j] |=> !v_out);
    end else begin : g_pass
      assign v_out = vld[j];
      assign s_out = nxt;
    end

    assign vld[j+1] = v_out;
    assign st[j+1]  = s_out;
  end

  assign valid_o = vld[STEPS];
  assign state_o = st[STEPS];
endmodule

// File: rtl/rc6_pipe.sv
module rc6_pipe
  import rc6_pkg::*;
#(
  parameter  int unsigned ROUNDS    = 10,
  parameter  int unsigned STAGES    = 2,
  localparam int unsigned KEY_WORDS = 2 * ROUNDS + 4,
  localparam int unsigned KEY_AW    = $clog2(KEY_WORDS),
  localparam int unsigned LATENCY   = ROUNDS * STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [BLOCK_W-1:0] in_data_i,
  input  logic               key_we_i,
  input  logic [KEY_AW-1:0]  key_addr_i,
  input  logic [WORD_W-1:0]  key_data_i,
  output logic               out_valid_o,
  output logic [BLOCK_W-1:0] out_data_o
);
  logic [KEY_WORDS-1:0][WORD_W-1:0] keys;
  logic                             accept;
  logic [ROUNDS:0]                  rv;
  rstate_t                          rs [ROUNDS+1];

  rc6_key_store #(
    .KEY_WORDS (KEY_WORDS),
    .ADDR_W    (KEY_AW)
  ) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (key_we_i),
    .addr_i (key_addr_i),
    .data_i (key_data_i),
    .keys_o (keys)
  );

  // subkey updates and block entry never share a cycle
  assign in_ready_o = !key_we_i;
  assign accept     = in_valid_i && in_ready_o;

  assign rv[0] = accept;
  assign rs[0] = load_block(in_data_i, keys[0], keys[1]);

  for (genvar i = 0; i < ROUNDS; i++) begin : g_round
    rc6_round #(
      .STAGES (STAGES)
    ) u_round (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (rv[i]),
      .state_i (rs[i]),
      .k0_i    (keys[2*i+2]),
      .k1_i    (keys[2*i+3]),
      .valid_o (rv[i+1]),
      .state_o (rs[i+1])
    );
  end

  assign out_valid_o = rv[ROUNDS];
  assign out_data_o  = unload_block(rs[ROUNDS], keys[2*ROUNDS+2], keys[2*ROUNDS+3]);

  // occupancy tracker for the checks below
  localparam int unsigned CNT_W = $clog2(LATENCY + 1) + 1;
  logic [CNT_W-1:0] inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(accept) - CNT_W'(out_valid_o);
  end

  p_out_has_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (inflight_q != '0));

  p_inflight_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(LATENCY));

  p_no_entry_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_we_i |=> (inflight_q <= $past(inflight_q)));
endmodule

// File: tb/rc6_pipe_bench.sv
module rc6_pipe_bench;
  localparam int ROUNDS = 10;
  localparam int KW     = 2 * ROUNDS + 4;
  localparam int KAW    = $clog2(KW);
  localparam int NDUT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           in_valid = 1'b0;
  logic [127:0]   in_data  = '0;
  logic           key_we   = 1'b0;
  logic [KAW-1:0] key_addr = '0;
  logic [31:0]    key_data = '0;

  logic         ov  [NDUT];
  logic         rdy [NDUT];
  logic [127:0] od  [NDUT];

  rc6_pipe #(.ROUNDS(ROUNDS), .STAGES(2)) u_rc6_pipe (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy[0]),
    .in_data_i(in_data), .key_we_i(key_we), .key_addr_i(key_addr),
    .key_data_i(key_data), .out_valid_o(ov[0]), .out_data_o(od[0]));

  rc6_pipe #(.ROUNDS(ROUNDS), .STAGES(1)) u_rc6_pipe_s1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy[1]),
    .in_data_i(in_data), .key_we_i(key_we), .key_addr_i(key_addr),
    .key_data_i(key_data), .out_valid_o(ov[1]), .out_data_o(od[1]));

  rc6_pipe #(.ROUNDS(ROUNDS), .STAGES(4)) u_rc6_pipe_s4 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy[2]),
    .in_data_i(in_data), .key_we_i(key_we), .key_addr_i(key_addr),
    .key_data_i(key_data), .out_valid_o(ov[2]), .out_data_o(od[2]));

  function automatic int lat(input int k);
    return ROUNDS * ((k == 0) ? 2 : (k == 1) ? 1 : 4);
  endfunction

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // reference model
  logic [31:0] kw [KW];

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [31:0] a, b, c, d, t, u, tmp;
    a = pt[31:0];
    b = pt[63:32] + kw[0];
    c = pt[95:64];
    d = pt[127:96] + kw[1];
    for (int i = 1; i <= ROUNDS; i++) begin
      t = rl(b * (2 * b + 1), 5);
      u = rl(d * (2 * d + 1), 5);
      a = rl(a ^ t, int'(u[4:0])) + kw[2*i];
      c = rl(c ^ u, int'(t[4:0])) + kw[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + kw[2*ROUNDS+2];
    c = c + kw[2*ROUNDS+3];
    return {d, c, b, a};
  endfunction

  // scoreboard: shared expected list, one read pointer per instance
  logic [127:0] exp_d   [$];
  int           exp_c   [$];
  string        exp_tag [$];
  int rd     [NDUT] = '{0, 0, 0};
  int run    [NDUT] = '{0, 0, 0};
  int maxrun [NDUT] = '{0, 0, 0};

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NDUT; k++) begin
        if (ov[k]) begin
          if (rd[k] >= exp_d.size()) begin
            chk(1'b0, "R10 spurious output", od[k], '0);
          end else begin
            chk(od[k] == exp_d[rd[k]], exp_tag[rd[k]], od[k], exp_d[rd[k]]);
            chk((cyc - exp_c[rd[k]]) == lat(k), "R2 latency",
                128'(cyc - exp_c[rd[k]]), 128'(lat(k)));
            rd[k]++;
          end
          run[k]++;
          if (run[k] > maxrun[k]) maxrun[k] = run[k];
        end else begin
          run[k] = 0;
        end
      end
    end
  end

  // driver tasks
  task automatic send(input logic [127:0] pt, input string tag);
    @(posedge clk); #1;
    key_we   = 1'b0;
    in_valid = 1'b1;
    in_data  = pt;
    exp_d.push_back(ref_enc(pt));
    exp_c.push_back(cyc);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      key_we   = 1'b0;
    end
  endtask

  task automatic wkey(input int a, input logic [31:0] v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    key_we   = 1'b1;
    key_addr = KAW'(a);
    key_data = v;
    if (a < KW) kw[a] = v;
  endtask

  logic [31:0] rs_state = 32'h1234_5678;
  function automatic logic [31:0] nxt_rand();
    rs_state ^= rs_state << 13;
    rs_state ^= rs_state >> 17;
    rs_state ^= rs_state << 5;
    return rs_state;
  endfunction

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < KW; i++) kw[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < NDUT; k++) begin
      chk(ov[k] == 1'b0, "R1 out_valid in reset", 128'(ov[k]), 128'(0));
      chk(rdy[k] == 1'b1, "R1 in_ready in reset", 128'(rdy[k]), 128'(1));
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NDUT; k++)
      chk(ov[k] == 1'b0, "R1 out_valid after reset", 128'(ov[k]), 128'(0));

    // R8: load subkeys
    for (int i = 0; i < KW; i++) wkey(i, 32'h9E37_79B9 * (i + 1) ^ 32'hB7E1_5163);
    idle(2);

    send('0, "R5 zero block whitening");
    send('1, "R4 all-ones block");
    send(128'h0F0E0D0C_0B0A0908_07060504_03020100, "R6 byte ramp");
    send(128'h1, "R6 byte0 to low A");
    idle(lat(2) + 4);

    // R3: back-to-back burst
    for (int i = 0; i < 24; i++)
      send({nxt_rand(), nxt_rand(), nxt_rand(), nxt_rand()}, "R3 burst data");
    idle(lat(2) + 4);
    for (int k = 0; k < NDUT; k++)
      chk(maxrun[k] >= 24, "R3 output run length", 128'(maxrun[k]), 128'(24));

    // R2: gapped traffic
    for (int i = 0; i < 6; i++) begin
      send({nxt_rand(), nxt_rand(), nxt_rand(), nxt_rand()}, "R2 gapped data");
      idle(i % 3 + 1);
    end
    idle(lat(2) + 4);

    // R7: block offered during a key write is dropped
    @(posedge clk); #1;
    key_we   = 1'b1;
    key_addr = KAW'(3);
    key_data = kw[3];
    in_valid = 1'b1;
    in_data  = '1;
    #1;
    for (int k = 0; k < NDUT; k++)
      chk(rdy[k] == 1'b0, "R7 ready low on key write", 128'(rdy[k]), 128'(0));
    idle(1);
    #1;
    for (int k = 0; k < NDUT; k++)
      chk(rdy[k] == 1'b1, "R7 ready back high", 128'(rdy[k]), 128'(1));
    idle(lat(2) + 4);
    for (int k = 0; k < NDUT; k++)
      chk(rd[k] == exp_d.size(), "R7 dropped block gave no output",
          128'(rd[k]), 128'(exp_d.size()));

    // R9: out-of-range writes leave subkeys alone
    for (int a = KW; a < (1 << KAW); a++) wkey(a, 32'hDEAD_BEEF + a);
    idle(1);
    send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R9 after oob writes");
    send('0, "R9 zero after oob writes");
    idle(lat(2) + 4);

    // R8: rewrite first and last subkeys
    wkey(0, 32'hA5A5_0001);
    wkey(KW - 1, 32'h5A5A_FFFE);
    wkey(2 * 5 + 1, 32'h0BAD_F00D);
    idle(1);
    send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R8 new subkeys");
    send({nxt_rand(), nxt_rand(), nxt_rand(), nxt_rand()}, "R8 new subkeys rand");
    idle(lat(2) + 4);

    for (int k = 0; k < NDUT; k++)
      chk(rd[k] == exp_d.size(), "R10 every block produced once",
          128'(rd[k]), 128'(exp_d.size()));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule